// File: doc/BRIEF.md
# Software-Selectable Clock Speed Swapper

This block derives a processor clock from one fixed oscillator and lets software change its rate while the processor runs. Three speeds are offered. Fast forwards the oscillator unchanged. Medium and Slow are 50% duty divisions of it, taken from taps of one free-running counter, so the two divided clocks keep a fixed phase relation. The Medium and Slow ratios come from two-bit board straps that are set at assembly. Software asks for a speed by writing a two-bit code. A reset always returns the block to Slow.

The processor behind this clock keeps its state in static registers. The clock may therefore be held low for a while, but it must never show a short pulse. A controller carries out each change through four named states. ST_RUN is steady operation. An accepted write moves it to ST_DRAIN, where the old source is gated off during one of its low phases. ST_DRAIN moves to ST_SYNC, where two rising edges of the new source are counted. ST_SYNC moves to ST_ARM, where the new source is enabled during one of its low phases, and ST_ARM then returns to ST_RUN. The Fast gate flop updates on the falling oscillator edge, so the pass-through path can only open or close while the oscillator is low. A pending flag is raised during a change and can be read back.

Top module: `clk_speed_swap`

## Requirements
- R1: While reset is asserted, and after it is released, the active speed is Slow (code 10) and no switch is pending.
- R2: Speed codes are 00 = Fast, 01 = Medium and 10 = Slow. The cur_sel output reports the code of the speed currently driving cpu_clk and never shows 11.
- R3: At Fast, cpu_clk follows the oscillator, with one high half-period and one low half-period per oscillator cycle.
- R4: At Medium, cpu_clk is the oscillator divided by 32 (strap 00), 64 (strap 01) or 128 (strap 10 or 11).
- R5: At Slow, cpu_clk is the oscillator divided by 64 (strap 00), 128 (strap 01) or 256 (strap 10 or 11).
- R6: A write of code 11 is ignored. No switch starts, and the speed stays the same.
- R7: A write of the speed already active, or any write made while a switch is pending, is ignored.
- R8: switch_pending reads 1 from the first clock edge after a write is accepted, and stays 1 until the new source drives cpu_clk.
- R9: A divided source is gated on or off only during one of its low phases. The new source is enabled only after two of its rising edges have been seen. At most one source is gated onto cpu_clk at any time.
- R10: The divided outputs have 50% duty cycle, with high and low phases of equal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fixed base oscillator |
| rst_n | input | 1 | Asynchronous reset, active low; selects Slow |
| wr_en | input | 1 | Write strobe for the speed select register |
| wr_sel | input | 2 | Requested speed code |
| med_strap | input | 2 | Assembly strap for the Medium ratio |
| slow_strap | input | 2 | Assembly strap for the Slow ratio |
| cpu_clk | output | 1 | Processor clock output |
| cur_sel | output | 2 | Code of the speed now driving cpu_clk |
| switch_pending | output | 1 | High while a speed change is in progress |

## Verification
The bench measures each high and low phase of cpu_clk in oscillator half-periods, for every strap setting. A wrong counter tap would show up as a doubled or halved phase, and an uneven duty cycle as unequal high and low phases. It sends code 11, a request for the speed already active, and a second request made while a switch is pending. A design that did not filter these would start a switch, or would land on the speed named by the later write. It also checks that pending rises one edge after the write and that a reset taken during Fast returns the block to Slow. The gating only in low phases and the one-source-at-a-time rule are covered by properties on the gate and tap signals.

// File: rtl/clk_swap_pkg.sv
package clk_swap_pkg;
    typedef enum logic [1:0] {
        SPD_FAST = 2'b00,
        SPD_MED  = 2'b01,
        SPD_SLOW = 2'b10
    } speed_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN,
        ST_SYNC,
        ST_ARM
    } swap_st_e;
endpackage

// File: rtl/clk_swap_div.sv
module clk_swap_div #(
    parameter int CNT_W         = 8,
    parameter int MED_LOG2_MIN  = 5,
    parameter int SLOW_LOG2_MIN = 6
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic [1:0] med_strap,
    input  logic [1:0] slow_strap,
    output logic       med_clk,
    output logic       slow_clk
);
    localparam int IDX_W = $clog2(CNT_W);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] med_idx;
    logic [IDX_W-1:0] slow_idx;

    // free-running counter; bit k toggles with period 2^(k+1)
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // strap to tap: smallest ratio 2^MIN sits on bit MIN-1
    always_comb begin
        unique case (med_strap)
            2'b00:   med_idx = IDX_W'(MED_LOG2_MIN - 1);
            2'b01:   med_idx = IDX_W'(MED_LOG2_MIN);
            default: med_idx = IDX_W'(MED_LOG2_MIN + 1);
        endcase
        unique case (slow_strap)
            2'b00:   slow_idx = IDX_W'(SLOW_LOG2_MIN - 1);
            2'b01:   slow_idx = IDX_W'(SLOW_LOG2_MIN);
            default: slow_idx = IDX_W'(SLOW_LOG2_MIN + 1);
        endcase
    end

    assign med_clk  = cnt_q[med_idx];
    assign slow_clk = cnt_q[slow_idx];
endmodule

// File: rtl/clk_swap_ctrl.sv
module clk_swap_ctrl
    import clk_swap_pkg::*;
#(
    parameter int SYNC_EDGES = 2
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic       med_clk,
    input  logic       slow_clk,
    output logic [1:0] cur_sel,
    output logic       busy,
    output logic       gate_fast_req,
    output logic       gate_med,
    output logic       gate_slow
);
    localparam int EC_W = $clog2(SYNC_EDGES + 1);

    swap_st_e         st_q, st_d;
    speed_e           cur_q, cur_d, tgt_q, tgt_d;
    logic [EC_W-1:0]  ecnt_q, ecnt_d;
    logic             prev_q, prev_d;
    logic             gf_q, gf_d, gm_q, gm_d, gs_q, gs_d;
    logic             src_old, src_new, new_rise, accept;

    // state register process
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            cur_q  <= SPD_SLOW;
            tgt_q  <= SPD_SLOW;
            ecnt_q <= '0;
            prev_q <= 1'b0;
            gf_q   <= 1'b0;
            gm_q   <= 1'b0;
            gs_q   <= 1'b1;
        end else begin
            st_q   <= st_d;
            cur_q  <= cur_d;
            tgt_q  <= tgt_d;
            ecnt_q <= ecnt_d;
            prev_q <= prev_d;
            gf_q   <= gf_d;
            gm_q   <= gm_d;
            gs_q   <= gs_d;
        end
    end

    always_comb begin
        src_old  = (cur_q == SPD_MED) ? med_clk : (cur_q == SPD_SLOW) ? slow_clk : 1'b0;
        src_new  = (tgt_q == SPD_MED) ? med_clk : (tgt_q == SPD_SLOW) ? slow_clk : 1'b0;
        new_rise = (tgt_q == SPD_FAST) ? 1'b1 : (src_new & ~prev_q);
        accept   = wr_en && (wr_sel != 2'b11) && (wr_sel != cur_q) && (st_q == ST_RUN);
    end

    // next-state and output process
    always_comb begin
        st_d   = st_q;
        cur_d  = cur_q;
        tgt_d  = tgt_q;
        ecnt_d = ecnt_q;
        prev_d = src_new;
        gf_d   = gf_q;
        gm_d   = gm_q;
        gs_d   = gs_q;
        unique case (st_q)
            ST_RUN: begin
                if (accept) begin
                    tgt_d = speed_e'(wr_sel);
                    st_d  = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                ecnt_d = '0;
                if (cur_q == SPD_FAST) begin
                    gf_d = 1'b0;
                    st_d = ST_SYNC;
                end else if (!src_old) begin
                    gm_d = 1'b0;
                    gs_d = 1'b0;
                    st_d = ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (new_rise) begin
                    ecnt_d = ecnt_q + 1'b1;
                    if (ecnt_q == EC_W'(SYNC_EDGES - 1)) st_d = ST_ARM;
                end
            end
            ST_ARM: begin
                if (tgt_q == SPD_FAST) begin
                    gf_d  = 1'b1;
                    cur_d = tgt_q;
                    st_d  = ST_RUN;
                end else if (!src_new) begin
                    gm_d  = (tgt_q == SPD_MED);
                    gs_d  = (tgt_q == SPD_SLOW);
                    cur_d = tgt_q;
                    st_d  = ST_RUN;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    assign cur_sel       = cur_q;
    assign busy          = (st_q != ST_RUN);
    assign gate_fast_req = gf_q;
    assign gate_med      = gm_q;
    assign gate_slow     = gs_q;
endmodule

// File: rtl/clk_swap_omux.sv
module clk_swap_omux (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic gate_fast_req,
    input  logic gate_med,
    input  logic gate_slow,
    input  logic med_clk,
    input  logic slow_clk,
    output logic cpu_clk,
    output logic fast_live
);
    // retimed on the falling edge so the pass-through opens only in a low phase
    always_ff @(negedge osc_clk or negedge rst_n) begin
        if (!rst_n) fast_live <= 1'b0;
        else        fast_live <= gate_fast_req;
    end

    assign cpu_clk = (osc_clk & fast_live) | (med_clk & gate_med) | (slow_clk & gate_slow);
endmodule

// File: rtl/clk_speed_swap.sv
module clk_speed_swap #(
    parameter int CNT_W         = 8,
    parameter int MED_LOG2_MIN  = 5,
    parameter int SLOW_LOG2_MIN = 6,
    parameter int SYNC_EDGES    = 2
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [1:0] med_strap,
    input  logic [1:0] slow_strap,
    output logic       cpu_clk,
    output logic [1:0] cur_sel,
    output logic       switch_pending
);
    logic med_clk, slow_clk;
    logic busy, gate_fast_req, gate_med, gate_slow, fast_live;

    clk_swap_div #(
        .CNT_W(CNT_W), .MED_LOG2_MIN(MED_LOG2_MIN), .SLOW_LOG2_MIN(SLOW_LOG2_MIN)
    ) u_div (
        .osc_clk(osc_clk), .rst_n(rst_n),
        .med_strap(med_strap), .slow_strap(slow_strap),
        .med_clk(med_clk), .slow_clk(slow_clk)
    );

    clk_swap_ctrl #(.SYNC_EDGES(SYNC_EDGES)) u_ctrl (
        .osc_clk(osc_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel),
        .med_clk(med_clk), .slow_clk(slow_clk),
        .cur_sel(cur_sel), .busy(busy),
        .gate_fast_req(gate_fast_req), .gate_med(gate_med), .gate_slow(gate_slow)
    );

    clk_swap_omux u_omux (
        .osc_clk(osc_clk), .rst_n(rst_n),
        .gate_fast_req(gate_fast_req), .gate_med(gate_med), .gate_slow(gate_slow),
        .med_clk(med_clk), .slow_clk(slow_clk),
        .cpu_clk(cpu_clk), .fast_live(fast_live)
    );

    assign switch_pending = busy | (gate_fast_req != fast_live);
endmodule

// File: rtl/clk_speed_swap_chk.sv
module clk_speed_swap_chk (
    input logic       osc_clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [1:0] cur_sel,
    input logic       switch_pending,
    input logic       med_clk,
    input logic       slow_clk,
    input logic       gate_fast_req,
    input logic       gate_med,
    input logic       gate_slow
);
    // R2
    sel_legal_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cur_sel != 2'b11);

    // R9
    one_source_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $onehot0({gate_fast_req, gate_med, gate_slow}));

    // R9
    med_on_low_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(gate_med) |-> !$past(med_clk));

    // R9
    med_off_low_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $fell(gate_med) |-> !$past(med_clk));

    // R9
    slow_on_low_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(gate_slow) |-> !$past(slow_clk));

    // R9
    slow_off_low_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $fell(gate_slow) |-> !$past(slow_clk));

    // R6
    bad_code_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11 && !switch_pending) |=> !switch_pending);

    // R8
    pend_rise_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'b11 && wr_sel != cur_sel && !switch_pending) |=> switch_pending);

    // R2
    sel_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !switch_pending |=> $stable(cur_sel));
endmodule

bind clk_speed_swap clk_speed_swap_chk u_chk (
    .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .cur_sel(cur_sel), .switch_pending(switch_pending),
    .med_clk(med_clk), .slow_clk(slow_clk),
    .gate_fast_req(gate_fast_req), .gate_med(gate_med), .gate_slow(gate_slow)
);

// File: tb/clk_speed_swap_tb.sv
`timescale 1ns/1ps
module clk_speed_swap_tb;
    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [1:0] wr_sel  = 2'b00;
    logic [1:0] med_strap  = 2'b00;
    logic [1:0] slow_strap = 2'b00;
    logic       cpu_clk;
    logic [1:0] cur_sel;
    logic       switch_pending;

    int total = 0;
    int bad   = 0;

    always #4 osc_clk = ~osc_clk;

    clk_speed_swap u_dut (
        .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .med_strap(med_strap), .slow_strap(slow_strap),
        .cpu_clk(cpu_clk), .cur_sel(cur_sel), .switch_pending(switch_pending)
    );

    typedef struct packed {
        logic [1:0]  code;
        logic [1:0]  ms;
        logic [1:0]  ss;
        logic [1:0]  esel;
        logic [15:0] ehalf;   // expected phase length in oscillator half-periods
    } vec_t;

    // R2 codes, R3 fast, R4 medium straps, R5 slow straps, R10 duty
    localparam vec_t VECS [8] = '{
        '{2'b00, 2'b00, 2'b00, 2'b00, 16'd1},
        '{2'b01, 2'b00, 2'b00, 2'b01, 16'd32},
        '{2'b10, 2'b00, 2'b00, 2'b10, 16'd64},
        '{2'b01, 2'b01, 2'b00, 2'b01, 16'd64},
        '{2'b00, 2'b01, 2'b00, 2'b00, 16'd1},
        '{2'b10, 2'b01, 2'b10, 2'b10, 16'd256},
        '{2'b01, 2'b10, 2'b10, 2'b01, 16'd128},
        '{2'b10, 2'b10, 2'b01, 2'b10, 16'd128}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(output logic s);
        @(osc_clk);
        #2;
        s = cpu_clk;
    endtask

    task automatic measure(output int hi, output int lo);
        logic s;
        int guard;
        hi = 0; lo = 0; guard = 0;
        sample(s);
        while (s && guard < 4000) begin sample(s); guard++; end
        while (!s && guard < 4000) begin sample(s); guard++; end
        while (s && guard < 4000) begin hi++; sample(s); guard++; end
        while (!s && guard < 4000) begin lo++; sample(s); guard++; end
    endtask

    task automatic write_sel(input logic [1:0] code);
        @(negedge osc_clk);
        wr_en = 1'b1; wr_sel = code;
        @(negedge osc_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            @(negedge osc_clk);
            #2;
            if (!switch_pending) break;
        end
    endtask

    initial begin
        repeat (2000000) @(posedge osc_clk);
        bad++; total++;
        $display("FAIL watchdog R1 R8 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi, lo;
        // R1: reset state
        repeat (3) @(negedge osc_clk);
        #1;
        chk(cur_sel == 2'b10, "R1 sel in reset", cur_sel, 2);
        chk(!switch_pending, "R1 pending in reset", switch_pending, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge osc_clk);
        chk(cur_sel == 2'b10, "R1 sel after reset", cur_sel, 2);
        measure(hi, lo);
        chk(hi == 64 && lo == 64, "R1 R5 slow period after reset", hi, 64);

        foreach (VECS[i]) begin
            med_strap  = VECS[i].ms;
            slow_strap = VECS[i].ss;
            write_sel(VECS[i].code);
            #2;
            chk(switch_pending, "R8 pending after write", switch_pending, 1);
            wait_idle();
            chk(cur_sel == VECS[i].esel, "R2 readback", cur_sel, VECS[i].esel);
            measure(hi, lo);
            chk(hi == int'(VECS[i].ehalf), "R3 R4 R5 high phase", hi, VECS[i].ehalf);
            chk(lo == hi, "R10 duty", lo, hi);
        end

        // to Fast for directed cases
        write_sel(2'b00);
        wait_idle();
        // R6: code 11 ignored
        write_sel(2'b11);
        #2;
        chk(!switch_pending, "R6 no switch on 11", switch_pending, 0);
        repeat (20) @(negedge osc_clk);
        chk(cur_sel == 2'b00, "R6 speed kept", cur_sel, 0);
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R6 fast period kept", hi, 1);
        // R7: same speed ignored
        write_sel(2'b00);
        #2;
        chk(!switch_pending, "R7 same speed ignored", switch_pending, 0);
        // R7: write while pending ignored
        write_sel(2'b10);
        @(negedge osc_clk);
        wr_en = 1'b1; wr_sel = 2'b01;
        @(negedge osc_clk);
        wr_en = 1'b0;
        wait_idle();
        chk(cur_sel == 2'b10, "R7 pending write ignored", cur_sel, 2);
        measure(hi, lo);
        chk(hi == 128, "R7 R5 slow strap01 period", hi, 128);

        // R1: reset during Fast returns to Slow
        write_sel(2'b00);
        wait_idle();
        @(negedge osc_clk);
        rst_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        rst_n = 1'b1;
        #2;
        chk(cur_sel == 2'b10, "R1 reset from fast", cur_sel, 2);
        chk(!switch_pending, "R1 no pending after reset", switch_pending, 0);
        measure(hi, lo);
        chk(hi == 128 && lo == 128, "R1 slow period after reset", hi, 128);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule